// File: doc/BRIEF.md
# Prescaled Timer/Counter with Two Compare Outputs

This block is a timer/counter for a small peripheral set inside a controller-style chip. On each clock cycle, the counter can stay still or advance. It can advance on every system clock, or once every 8, 64, 256 or 1024 clocks through a free-running prescaler. It can also advance once for each rising or falling edge of an external pin. The pin is brought into the clock domain through a two-flop synchronizer.

The counter has two compare units. Each one raises a sticky match flag when the counter advances onto its compare value. On that same match, each unit can also drive its own output pin: leave it alone, toggle it, clear it or set it. When the counter wraps from all ones to zero, a sticky overflow flag is raised. Software clears any flag by writing a one to its bit.

Software reaches the block through a byte-wide register port. When the counter is 16 bits wide, one shared holding byte makes each 16-bit transfer atomic. Reading the low byte captures the high byte at the same moment. Writing the high byte stages it, and the following low-byte write loads the whole word in one cycle. The counter width is set by a parameter and may be 8 or 16 bits.

Top module: `ptimer_top`

## Requirements
- R1: After reset, the control register, counter, compare registers, flags and both output pins are all zero, so the timer starts stopped.
- R2: With source code 0 (stopped), the counter holds its value unless software writes it.
- R3: With source code 1, the counter advances by one on every clock edge.
- R4: Source codes 2, 3, 4 and 5 divide the clock by 8, 64, 256 and 1024. The prescaler is held at zero while the source is not a divided one. The first increment after selecting a divider of N happens on the N-th clock edge after the edge that wrote the control register.
- R5: Source code 7 counts rising edges of `ext_in` and source code 6 counts falling edges. An edge of the other polarity has no effect. After `ext_in` changes just past edge E0, the counter shows the increment after edge E0+3.
- R6: When a count step moves the counter from all ones to zero, flag bit 2 (overflow) is set on that same edge.
- R7: When a count step moves the counter onto the value of compare A, flag bit 0 is set. Compare B does the same with flag bit 1. A software write to the counter never raises a match.
- R8: The control register holds the action of compare A in bits 4:3 and the action of compare B in bits 6:5. The codes are 0 none, 1 toggle, 2 clear and 3 set. The unit's pin (`oc_a` or `oc_b`) takes the action on the same edge that sets its match flag.
- R9: Flags stay set until software writes a one to their bit of the flag register. Writing zero to a bit leaves that flag unchanged. If a flag is set and cleared on the same edge, the set wins.
- R10: In the 16-bit variant, a read of counter-low copies the counter's high byte into the holding byte. A read of counter-high returns the holding byte, so it matches the earlier low read even if the counter has moved since.
- R11: A write to any high address stores the byte in the holding byte only. A write to a low address loads {holding byte, data} into the counter or compare register in one cycle. A counter write takes priority over a count step on the same edge.
- R12: Register addresses: 0 control (source in bits 2:0), 1 counter low, 2 counter high, 3/4 compare A low/high, 5/6 compare B low/high, 7 flags. All of these read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| ext_in | input | 1 | External count pin, asynchronous |
| oc_a | output | 1 | Compare A output pin |
| oc_b | output | 1 | Compare B output pin |
| flags_o | output | 3 | Sticky flags: bit 0 match A, bit 1 match B, bit 2 overflow |

## Verification
A register write takes effect at the clock edge that ends its strobe cycle. From then on the counter moves one step per edge in clock mode. In divided modes it moves on the N-th edge. For an external pin change it moves three edges later, because of the two synchronizer flops plus the edge-history flop. Flags and pins settle on the same edge as the count step that causes them. The bench drives every input one time unit after a rising edge. Its driver task queues the expected value for each probe, and the monitor compares on the falling edge inside that probe's cycle. Each expected value comes from counting these edges from the stimulus that caused it.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_CLK      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_EXT_FALL = 3'd6,
        SRC_EXT_RISE = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;

    localparam logic [2:0] ADR_CTRL    = 3'd0;
    localparam logic [2:0] ADR_CNT_LO  = 3'd1;
    localparam logic [2:0] ADR_CNT_HI  = 3'd2;
    localparam logic [2:0] ADR_CMPA_LO = 3'd3;
    localparam logic [2:0] ADR_CMPA_HI = 3'd4;
    localparam logic [2:0] ADR_CMPB_LO = 3'd5;
    localparam logic [2:0] ADR_CMPB_HI = 3'd6;
    localparam logic [2:0] ADR_FLAGS   = 3'd7;

    localparam int PRE_W = 10;

endpackage

// File: rtl/ptimer_tick.sv
module ptimer_tick
    import ptimer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic ext_in,
    output logic tick
);

    logic [PRE_W-1:0]     pre_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 pre_run;
    logic                 pin_now;
    logic                 pin_old;

    always_comb begin
        pre_run = (src == SRC_DIV8) || (src == SRC_DIV64) ||
                  (src == SRC_DIV256) || (src == SRC_DIV1024);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !pre_run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
        end
    end

    assign pin_now = sync_q[SYNC_STAGES-1];
    assign pin_old = sync_q[SYNC_STAGES];

    always_comb begin
        unique case (src)
            SRC_OFF:      tick = 1'b0;
            SRC_CLK:      tick = 1'b1;
            SRC_DIV8:     tick = &pre_q[2:0];
            SRC_DIV64:    tick = &pre_q[5:0];
            SRC_DIV256:   tick = &pre_q[7:0];
            SRC_DIV1024:  tick = &pre_q[9:0];
            SRC_EXT_FALL: tick = pin_old & ~pin_now;
            SRC_EXT_RISE: tick = pin_now & ~pin_old;
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptimer_cmp.sv
module ptimer_cmp
    import ptimer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic [CNT_W-1:0] cmp_val,
    input  act_e             act,
    output logic             hit,
    output logic             pin
);

    always_comb begin
        hit = adv && (cnt_inc == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (hit) begin
            unique case (act)
                ACT_NONE:   pin <= pin;
                ACT_TOGGLE: pin <= ~pin;
                ACT_CLEAR:  pin <= 1'b0;
                ACT_SET:    pin <= 1'b1;
                default:    pin <= pin;
            endcase
        end
    end

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_in,
    output logic       oc_a,
    output logic       oc_b,
    output logic [2:0] flags_o
);

    localparam int N_CMP = 2;
    localparam logic WIDE = (CNT_W > 8);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [6:0]                  ctrl_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [7:0]                  tmp_q;
    logic [2:0]                  flg_q;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
    logic [N_CMP-1:0][1:0]       act_v;
    logic [N_CMP-1:0]            hit_v;
    logic [N_CMP-1:0]            pin_v;
    logic                        tick;
    logic                        cnt_wr;
    logic                        adv;
    logic [CNT_W-1:0]            cnt_inc;
    logic [15:0]                 word_pad;
    logic [CNT_W-1:0]            word_w;
    logic [15:0]                 cnt_pad;
    logic [N_CMP-1:0][15:0]      cmp_pad;
    logic [2:0]                  flg_set;
    logic [2:0]                  flg_clr;

    assign cnt_wr   = bus_wr && (bus_addr == ADR_CNT_LO);
    assign adv      = tick && !cnt_wr;
    assign cnt_inc  = cnt_q + 1'b1;
    assign word_pad = {tmp_q, bus_wdata};
    assign word_w   = word_pad[CNT_W-1:0];
    assign cnt_pad  = 16'(cnt_q);
    assign act_v    = {ctrl_q[6:5], ctrl_q[4:3]};

    ptimer_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src_e'(ctrl_q[2:0])),
        .ext_in (ext_in),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && bus_addr == ADR_CTRL) begin
            ctrl_q <= bus_wdata[6:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q <= '0;
        end else if (bus_wr && (bus_addr == ADR_CNT_HI || bus_addr == ADR_CMPA_HI ||
                                bus_addr == ADR_CMPB_HI)) begin
            tmp_q <= bus_wdata;
        end else if (bus_rd && bus_addr == ADR_CNT_LO) begin
            tmp_q <= cnt_pad[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= word_w;
        end else if (tick) begin
            cnt_q <= cnt_inc;
        end
    end

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        localparam logic [2:0] LO_ADR = 3'(ADR_CMPA_LO + 2 * i);
        logic [CNT_W-1:0] cmp_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_r <= '0;
            end else if (bus_wr && bus_addr == LO_ADR) begin
                cmp_r <= word_w;
            end
        end

        assign cmp_q[i]   = cmp_r;
        assign cmp_pad[i] = 16'(cmp_r);

        ptimer_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .cnt_inc (cnt_inc),
            .cmp_val (cmp_r),
            .act     (act_e'(act_v[i])),
            .hit     (hit_v[i]),
            .pin     (pin_v[i])
        );
    end

    assign flg_set = {adv && (cnt_q == ALL_ONES), hit_v[1], hit_v[0]};
    assign flg_clr = (bus_wr && bus_addr == ADR_FLAGS) ? bus_wdata[2:0] : 3'b000;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= (flg_q & ~flg_clr) | flg_set;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CTRL:    bus_rdata = {1'b0, ctrl_q};
            ADR_CNT_LO:  bus_rdata = cnt_pad[7:0];
            ADR_CNT_HI:  bus_rdata = WIDE ? tmp_q : 8'h00;
            ADR_CMPA_LO: bus_rdata = cmp_pad[0][7:0];
            ADR_CMPA_HI: bus_rdata = cmp_pad[0][15:8];
            ADR_CMPB_LO: bus_rdata = cmp_pad[1][7:0];
            ADR_CMPB_HI: bus_rdata = cmp_pad[1][15:8];
            ADR_FLAGS:   bus_rdata = {5'b0, flg_q};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign oc_a    = pin_v[0];
    assign oc_b    = pin_v[1];
    assign flags_o = flg_q;

endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [6:0]       ctrl_q,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [7:0]       tmp_q,
    input logic [CNT_W-1:0] cmp_a,
    input logic [2:0]       flg_q
);

    logic             cnt_wr;
    logic [15:0]      word_pad;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_wr   = bus_wr && (bus_addr == 3'd1);
    assign word_pad = {tmp_q, bus_wdata};
    assign cnt_nxt  = cnt_q + 1'b1;

    // R2
    a_r2_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2:0] == 3'd0 && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    // R3
    a_r3_clk_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2:0] == 3'd1 && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R4
    a_r4_div_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2:0] >= 3'd2 && ctrl_q[2:0] <= 3'd5 && !cnt_wr) |=>
        ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));

    // R5
    a_r5_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2:1] == 2'b11 && !tick && !cnt_wr) |=> $stable(cnt_q));

    // R6
    a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == {CNT_W{1'b1}}) |=> flg_q[2]);

    // R7
    a_r7_match_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_nxt == cmp_a) |=> flg_q[0]);

    // R9
    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[2] && !(bus_wr && bus_addr == 3'd7 && bus_wdata[2])) |=> flg_q[2]);

    // R11
    a_r11_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == CNT_W'($past(word_pad))));

endmodule

bind ptimer_top ptimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .tmp_q     (tmp_q),
    .cmp_a     (cmp_q[0]),
    .flg_q     (flg_q)
);

// File: tb/ptimer_top_tb.sv
`timescale 1ns/1ps
module ptimer_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_in = 1'b0;
    logic       oc_a;
    logic       oc_b;
    logic [2:0] flags_o;

    always #4 clk = ~clk;

    ptimer_top #(.CNT_W(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_in    (ext_in),
        .oc_a      (oc_a),
        .oc_b      (oc_b),
        .flags_o   (flags_o)
    );

    // kind 0: bus read data, kind 1: {oc_b, oc_a}, kind 2: flags_o
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  chk_req = 1'b0;
    logic  done = 1'b0;
    int    wd_cnt = 0;

    always @(negedge clk) begin
        item_t      it;
        logic [7:0] act;
        if (chk_req && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {6'b0, oc_b, oc_a};
                default: act = {5'b0, flags_o};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [2:0] a, input logic [7:0] e,
                       input string tag);
        item_t it;
        it.kind = kind;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        chk_req = 1'b1;
        if (kind == 0) begin
            bus_rd = 1'b1;
            bus_addr = a;
        end
        @(posedge clk);
        #1;
        chk_req = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic presc(input logic [7:0] src, input int n, input string tag);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, src);
        idle(n - 1);
        chk(0, 3'd1, 8'h00, tag);
        chk(0, 3'd1, 8'h01, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        chk(0, 3'd0, 8'h00, "R1 control");
        chk(0, 3'd1, 8'h00, "R1 counter low");
        chk(2, 3'd0, 8'h00, "R1 flags");
        chk(1, 3'd0, 8'h00, "R1 pins");

        // R11 staged write, R10 latched read, R2 hold while stopped
        wr(3'd2, 8'h12);
        wr(3'd1, 8'h34);
        chk(0, 3'd1, 8'h34, "R11 low after commit");
        chk(0, 3'd2, 8'h12, "R10 high from holding byte");
        wr(3'd2, 8'h77);
        chk(0, 3'd1, 8'h34, "R11 high write alone leaves counter");
        chk(0, 3'd2, 8'h12, "R10 low read relatches high");

        // R10 atomic read across a carry, R3 clock mode
        wr(3'd2, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h01);
        chk(0, 3'd1, 8'hFF, "R10 low before carry");
        chk(0, 3'd2, 8'h00, "R10 high latched before carry");
        wr(3'd0, 8'h00);
        chk(0, 3'd1, 8'h02, "R3 low after three steps");
        chk(0, 3'd2, 8'h01, "R3 high after three steps");
        idle(5);
        chk(0, 3'd1, 8'h02, "R2 stopped low");
        chk(0, 3'd2, 8'h01, "R2 stopped high");

        // R6 overflow, R7 matches, R8 set and toggle, R12 readback
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h05);
        wr(3'd6, 8'h00);
        wr(3'd5, 8'h03);
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'hFE);
        wr(3'd0, 8'h39);
        idle(7);
        chk(2, 3'd0, 8'h07, "R6 R7 overflow and both matches");
        chk(1, 3'd0, 8'h03, "R8 set on A, toggle on B");
        chk(0, 3'd0, 8'h39, "R12 control readback");
        wr(3'd0, 8'h38);
        chk(0, 3'd1, 8'h09, "R3 low after run");
        chk(0, 3'd3, 8'h05, "R12 compare A low");
        chk(0, 3'd4, 8'h00, "R12 compare A high");
        chk(0, 3'd5, 8'h03, "R12 compare B low");
        wr(3'd7, 8'h04);
        chk(0, 3'd7, 8'h03, "R9 only overflow cleared");
        wr(3'd7, 8'h03);
        chk(2, 3'd0, 8'h00, "R9 all cleared");

        // R8 clear and none actions
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h02);
        wr(3'd6, 8'h00);
        wr(3'd5, 8'h02);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h00);
        chk(2, 3'd0, 8'h00, "R7 no match on counter write");
        wr(3'd0, 8'h11);
        idle(2);
        chk(1, 3'd0, 8'h02, "R8 clear on A, none on B");
        chk(2, 3'd0, 8'h03, "R7 both matches");
        wr(3'd0, 8'h10);
        wr(3'd7, 8'h07);

        // R11 write wins over a count step
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h40);
        wr(3'd1, 8'h00);
        chk(0, 3'd1, 8'h00, "R11 write over count low");
        chk(0, 3'd2, 8'h40, "R11 write over count high");
        wr(3'd0, 8'h00);

        // R4 prescaler taps
        presc(8'h02, 8, "R4 divide by 8");
        presc(8'h03, 64, "R4 divide by 64");
        presc(8'h05, 1024, "R4 divide by 1024");

        // R5 external edges
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h07);
        ext_in = 1'b1;
        idle(2);
        chk(0, 3'd1, 8'h00, "R5 rising not yet through sync");
        chk(0, 3'd1, 8'h01, "R5 rising counted");
        ext_in = 1'b0;
        idle(4);
        chk(0, 3'd1, 8'h01, "R5 falling ignored in rising mode");
        wr(3'd0, 8'h06);
        ext_in = 1'b1;
        idle(4);
        chk(0, 3'd1, 8'h01, "R5 rising ignored in falling mode");
        ext_in = 1'b0;
        idle(2);
        chk(0, 3'd1, 8'h01, "R5 falling not yet through sync");
        chk(0, 3'd1, 8'h02, "R5 falling counted");

        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule